// File: doc/BRIEF.md
# Bit-Band Alias Bridge

This block is a memory-mapped slave that turns single-bit accesses into ordinary memory traffic. It decodes two alias windows. Every aligned 32-bit word inside a window stands for one bit of a smaller target region. A load through the alias returns that one bit in bit 0. A store through the alias changes only that bit. The bridge does this with a locked read-modify-write on a downstream request/acknowledge port.

Upstream requests are taken one at a time. Each request carries an address, a size of 1, 2 or 4 bytes, a write flag and write data. `req_ready` falls while a request is in flight. The result comes back as a one-cycle `rsp_valid` pulse together with read data and an error flag.

The downstream access uses the same byte count as the upstream request. Its address is the mapped target address rounded down to a multiple of that size. Downstream data is little-endian and right-justified: byte 0 of the access sits in bits [7:0].

Top module: `bitband_bridge`

## Requirements
- R1: An address hits window i when its bits above SPAN_LOG2 equal those of ALIAS_BASE[i]; the defaults are 0x2200_0000 and 0x4200_0000 with SPAN_LOG2 = 25. A request that hits no window returns rsp_err = 1 and makes no downstream access.
- R2: The downstream address is TARGET_BASE[i] OR ((offset within the window) >> 5), with its low bits cleared to a multiple of the access size. mem_size equals the request size in bytes.
- R3: A read makes exactly one unlocked downstream read. It returns the selected bit in rsp_rdata[0] with rsp_rdata[31:1] = 0 and rsp_err = 0.
- R4: The bit position is (offset >> 2) AND (8·size − 1). It is taken from the right-justified downstream data: byte lane bitpos >> 3, bit bitpos AND 7.
- R5: A write reads `size` bytes and then writes the same `size` bytes to the same address. The selected bit becomes req_wdata[0] and every other bit keeps its value.
- R6: mem_lock is high on every downstream write. It stays high from the read of a read-modify-write through its write, and it is low during the read of a plain load.
- R7: If the downstream read returns mem_err, the response carries rsp_err = 1 and no downstream write follows.
- R8: If the downstream write returns mem_err, the write response carries rsp_err = 1.
- R9: A req_size other than 1, 2 or 4 (3-bit byte count) returns rsp_err = 1 with no downstream access.
- R10: req_ready is low from the cycle after a request is accepted until the response. rsp_valid is a single-cycle pulse. mem_req and mem_addr hold steady until mem_ack.
- R11: While in reset and just after it, req_ready = 1, rsp_valid = 0 and mem_req = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Upstream request present |
| req_ready | output | 1 | Bridge idle, request accepted this cycle if valid |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Alias address |
| req_size | input | 3 | Access size in bytes (1, 2, 4) |
| req_wdata | input | 32 | Store data; bit 0 is the new bit value |
| rsp_valid | output | 1 | Response pulse |
| rsp_rdata | output | 32 | Selected bit in bit 0 |
| rsp_err | output | 1 | Request failed |
| mem_req | output | 1 | Downstream request, held until mem_ack |
| mem_we | output | 1 | Downstream write |
| mem_lock | output | 1 | Downstream bus lock |
| mem_addr | output | ADDR_W | Downstream byte address, size aligned |
| mem_size | output | 3 | Downstream size in bytes |
| mem_wdata | output | 32 | Downstream write data, right-justified |
| mem_ack | input | 1 | Downstream completion |
| mem_rdata | input | 32 | Downstream read data, right-justified |
| mem_err | input | 1 | Downstream error with mem_ack |

## Verification
The bench builds the bridge with SPAN_LOG2 = 10. Each alias window is then 256 words and maps onto 32 target bytes, so every alias word of both windows can be read at every legal size. Word-size writes also cover every alias word, and byte and halfword writes each cover a full target region, with the whole target memory compared against an arithmetic shadow after each write. The small window puts both edges of each window within easy reach. The bench also injects read and write errors and drives the illegal size codes.

// File: rtl/bb_pkg.sv
package bb_pkg;

    localparam int DATA_W   = 32;
    localparam int BITPOS_W = $clog2(DATA_W);
    localparam int SIZE_W   = 3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_WR   = 2'd2,
        ST_RSP  = 2'd3
    } bb_state_e;

endpackage

// File: rtl/bb_window_decode.sv
module bb_window_decode #(
    parameter int ADDR_W    = 32,
    parameter int NUM_WIN   = 2,
    parameter int SPAN_LOG2 = 25,
    parameter logic [NUM_WIN-1:0][ADDR_W-1:0] ALIAS_BASE  = {32'h4200_0000, 32'h2200_0000},
    parameter logic [NUM_WIN-1:0][ADDR_W-1:0] TARGET_BASE = {32'h4000_0000, 32'h2000_0000}
) (
    input  logic [ADDR_W-1:0]  addr,
    output logic [NUM_WIN-1:0] win_hit,
    output logic [ADDR_W-1:0]  tgt_addr
);

    localparam int TAG_W = ADDR_W - SPAN_LOG2;

    logic [NUM_WIN-1:0][ADDR_W-1:0] win_tgt;
    logic [ADDR_W-1:0]              offset_ext;

    assign offset_ext = {{TAG_W{1'b0}}, addr[SPAN_LOG2-1:0]};

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
        assign win_hit[i] = (addr[ADDR_W-1:SPAN_LOG2] == ALIAS_BASE[i][ADDR_W-1:SPAN_LOG2]);
        assign win_tgt[i] = TARGET_BASE[i] | (offset_ext >> 5);
    end

    always_comb begin
        tgt_addr = '0;
        for (int i = 0; i < NUM_WIN; i++) begin
            if (win_hit[i]) begin
                tgt_addr = tgt_addr | win_tgt[i];
            end
        end
    end

endmodule

// File: rtl/bb_bit_locator.sv
module bb_bit_locator
    import bb_pkg::*;
(
    input  logic [SIZE_W-1:0]   size,
    input  logic [4:0]          word_idx,
    output logic                size_ok,
    output logic [BITPOS_W-1:0] bitpos,
    output logic [1:0]          low_mask
);

    always_comb begin
        size_ok  = 1'b1;
        bitpos   = '0;
        low_mask = 2'b00;
        unique case (size)
            3'd1: begin
                bitpos   = {2'b00, word_idx[2:0]};
                low_mask = 2'b00;
            end
            3'd2: begin
                bitpos   = {1'b0, word_idx[3:0]};
                low_mask = 2'b01;
            end
            3'd4: begin
                bitpos   = word_idx;
                low_mask = 2'b11;
            end
            default: size_ok = 1'b0;
        endcase
    end

endmodule

// File: rtl/bb_bit_merge.sv
module bb_bit_merge
    import bb_pkg::*;
(
    input  logic [SIZE_W-1:0]   size,
    input  logic [BITPOS_W-1:0] bitpos,
    input  logic [DATA_W-1:0]   rdata,
    input  logic                wbit,
    output logic                bit_out,
    output logic [DATA_W-1:0]   wdata
);

    logic [DATA_W-1:0] lane_mask;
    logic [DATA_W-1:0] sel_mask;

    always_comb begin
        unique case (size)
            3'd1:    lane_mask = 32'h0000_00FF;
            3'd2:    lane_mask = 32'h0000_FFFF;
            default: lane_mask = 32'hFFFF_FFFF;
        endcase
        sel_mask = DATA_W'(1) << bitpos;
        bit_out  = rdata[bitpos];
        if (wbit) begin
            wdata = (rdata | sel_mask) & lane_mask;
        end else begin
            wdata = (rdata & ~sel_mask) & lane_mask;
        end
    end

endmodule

// File: rtl/bitband_bridge.sv
module bitband_bridge
    import bb_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int NUM_WIN   = 2,
    parameter int SPAN_LOG2 = 25,
    parameter logic [NUM_WIN-1:0][ADDR_W-1:0] ALIAS_BASE  = {32'h4200_0000, 32'h2200_0000},
    parameter logic [NUM_WIN-1:0][ADDR_W-1:0] TARGET_BASE = {32'h4000_0000, 32'h2000_0000}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [2:0]        req_size,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic              rsp_err,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_lock,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [2:0]        mem_size,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_err
);

    typedef struct packed {
        bb_state_e           st;
        logic                is_wr;
        logic                wbit;
        logic [ADDR_W-1:0]   addr;
        logic [SIZE_W-1:0]   size;
        logic [BITPOS_W-1:0] bitpos;
        logic [DATA_W-1:0]   wdata;
        logic [DATA_W-1:0]   rdata;
        logic                err;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [NUM_WIN-1:0]  win_hit;
    logic [ADDR_W-1:0]   tgt_addr;
    logic                size_ok;
    logic [BITPOS_W-1:0] req_bitpos;
    logic [1:0]          low_mask;
    logic                fetched_bit;
    logic [DATA_W-1:0]   merged_data;
    logic [ADDR_W-1:0]   aligned_addr;
    logic                unused_wdata;

    assign unused_wdata = ^req_wdata[31:1];

    bb_window_decode #(
        .ADDR_W     (ADDR_W),
        .NUM_WIN    (NUM_WIN),
        .SPAN_LOG2  (SPAN_LOG2),
        .ALIAS_BASE (ALIAS_BASE),
        .TARGET_BASE(TARGET_BASE)
    ) u_decode (
        .addr    (req_addr),
        .win_hit (win_hit),
        .tgt_addr(tgt_addr)
    );

    bb_bit_locator u_locate (
        .size    (req_size),
        .word_idx(req_addr[6:2]),
        .size_ok (size_ok),
        .bitpos  (req_bitpos),
        .low_mask(low_mask)
    );

    bb_bit_merge u_merge (
        .size   (ctl_q.size),
        .bitpos (ctl_q.bitpos),
        .rdata  (mem_rdata),
        .wbit   (ctl_q.wbit),
        .bit_out(fetched_bit),
        .wdata  (merged_data)
    );

    assign aligned_addr = tgt_addr & ~{{(ADDR_W-2){1'b0}}, low_mask};

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    ctl_d.is_wr  = req_write;
                    ctl_d.wbit   = req_wdata[0];
                    ctl_d.addr   = aligned_addr;
                    ctl_d.size   = req_size;
                    ctl_d.bitpos = req_bitpos;
                    ctl_d.wdata  = '0;
                    ctl_d.rdata  = '0;
                    ctl_d.err    = 1'b0;
                    if (!(|win_hit) || !size_ok) begin
                        ctl_d.err = 1'b1;
                        ctl_d.st  = ST_RSP;
                    end else begin
                        ctl_d.st  = ST_RD;
                    end
                end
            end
            ST_RD: begin
                if (mem_ack) begin
                    if (mem_err) begin
                        ctl_d.err = 1'b1;
                        ctl_d.st  = ST_RSP;
                    end else if (ctl_q.is_wr) begin
                        ctl_d.wdata = merged_data;
                        ctl_d.st    = ST_WR;
                    end else begin
                        ctl_d.rdata = {{(DATA_W-1){1'b0}}, fetched_bit};
                        ctl_d.st    = ST_RSP;
                    end
                end
            end
            ST_WR: begin
                if (mem_ack) begin
                    ctl_d.err = mem_err;
                    ctl_d.st  = ST_RSP;
                end
            end
            default: begin
                ctl_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign req_ready = (ctl_q.st == ST_IDLE);
    assign rsp_valid = (ctl_q.st == ST_RSP);
    assign rsp_rdata = ctl_q.rdata;
    assign rsp_err   = ctl_q.err;
    assign mem_req   = (ctl_q.st == ST_RD) || (ctl_q.st == ST_WR);
    assign mem_we    = (ctl_q.st == ST_WR);
    assign mem_lock  = ((ctl_q.st == ST_RD) && ctl_q.is_wr) || (ctl_q.st == ST_WR);
    assign mem_addr  = ctl_q.addr;
    assign mem_size  = ctl_q.size;
    assign mem_wdata = ctl_q.wdata;

    // R1: a decoded address selects at most one window
    p_one_window_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> $onehot0(win_hit));

    // R1 and R9: rejected requests never reach downstream
    p_reject_no_access_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (!(|win_hit) || !size_ok)) |=> !mem_req);

    // R2: downstream address aligned to the access size
    p_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (((mem_addr[1:0]) & (mem_size[1:0] - 2'd1)) == 2'b00));

    // R3: read data carries a single bit
    p_single_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_rdata[31:1] == 31'd0));

    // R6: every downstream write is locked
    p_lock_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> mem_lock);

    // R6: lock not dropped between the read and the write of a store
    p_lock_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_lock && mem_ack && !mem_err) |=> (mem_req && mem_we && mem_lock));

    // R7: a failed fetch ends the transaction
    p_rd_err_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_ack && mem_err) |=> (!mem_req && rsp_valid && rsp_err));

    // R10: busy after acceptance, single-cycle response, held request
    p_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    p_rsp_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

endmodule

// File: tb/bitband_bridge_bench.sv
module bitband_bridge_bench;

    localparam int SPAN_LOG2 = 10;
    localparam int NWORDS    = 1 << (SPAN_LOG2 - 2);
    localparam int NBYTES    = 1 << (SPAN_LOG2 - 5);
    localparam logic [31:0] AB0 = 32'h2200_0000;
    localparam logic [31:0] AB1 = 32'h4200_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic [2:0]  req_size = 3'd4;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        rsp_err;
    logic        mem_req, mem_we, mem_lock;
    logic [31:0] mem_addr;
    logic [2:0]  mem_size;
    logic [31:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        mem_err = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;
    int xfer_cnt = 0;
    int lock_bad = 0;
    bit cur_is_wr = 1'b0;
    bit inj_rd_err = 1'b0;
    bit inj_wr_err = 1'b0;

    logic [7:0] mem [2][NBYTES];
    logic [7:0] shadow [2][NBYTES];

    always #5 clk = ~clk;

    bitband_bridge #(
        .SPAN_LOG2(SPAN_LOG2)
    ) u_bitband_bridge (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .mem_req(mem_req), .mem_we(mem_we), .mem_lock(mem_lock),
        .mem_addr(mem_addr), .mem_size(mem_size), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .mem_err(mem_err)
    );

    // Downstream memory model: acknowledges one cycle after a request.
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
            mem_err <= 1'b0;
        end else if (mem_ack) begin
            mem_ack <= 1'b0;
            mem_err <= 1'b0;
        end else if (mem_req) begin
            int w;
            int base;
            logic [31:0] rd;
            bit e;
            w    = mem_addr[30] ? 1 : 0;
            base = int'(mem_addr[SPAN_LOG2-6:0]);
            e    = mem_we ? inj_wr_err : inj_rd_err;
            rd   = '0;
            xfer_cnt <= xfer_cnt + 1;
            if (mem_we && !mem_lock) lock_bad <= lock_bad + 1;
            if (!mem_we && (mem_lock != cur_is_wr)) lock_bad <= lock_bad + 1;
            for (int b = 0; b < int'(mem_size); b++) begin
                rd[8*b +: 8] = mem[w][(base + b) % NBYTES];
                if (mem_we && !e) mem[w][(base + b) % NBYTES] = mem_wdata[8*b +: 8];
            end
            mem_rdata <= rd;
            mem_err   <= e;
            mem_ack   <= 1'b1;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_op(input bit wr, input logic [31:0] addr, input logic [2:0] size,
                         input bit wbit, output logic [31:0] rd, output bit err, output int xfers);
        int start;
        int guard;
        start = xfer_cnt;
        cur_is_wr = wr;
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = addr;
        req_size  = size;
        req_wdata = {31'h5A5A_5A5A, wbit};
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == 1'b0, "R10 ready low after accept", {31'd0, req_ready}, 32'd0);
        guard = 0;
        while (!rsp_valid && guard < 100) begin
            @(negedge clk);
            guard++;
        end
        if (guard >= 100) check(1'b0, "R10 response timeout", 32'd0, 32'd1);
        rd  = rsp_rdata;
        err = rsp_err;
        @(negedge clk);
        check(rsp_valid == 1'b0, "R10 rsp pulse one cycle", {31'd0, rsp_valid}, 32'd0);
        xfers = xfer_cnt - start;
    endtask

    function automatic int exp_byte(input int off, input int size);
        int ua;
        int bp;
        ua = ((off & ((1 << SPAN_LOG2) - 1)) >> 5) & ~(size - 1);
        bp = (off >> 2) & (size * 8 - 1);
        return ua + (bp >> 3);
    endfunction

    function automatic int exp_bit(input int off, input int size);
        return ((off >> 2) & (size * 8 - 1)) & 7;
    endfunction

    function automatic bit mem_matches();
        for (int w = 0; w < 2; w++)
            for (int i = 0; i < NBYTES; i++)
                if (mem[w][i] !== shadow[w][i]) return 1'b0;
        return 1'b1;
    endfunction

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        bit err;
        int xf;
        logic [31:0] ab;
        int sz;
        int bi;

        for (int w = 0; w < 2; w++)
            for (int i = 0; i < NBYTES; i++) begin
                mem[w][i]    = 8'((i * 37) + (w * 91) + 5);
                shadow[w][i] = 8'((i * 37) + (w * 91) + 5);
            end

        repeat (3) @(negedge clk);
        check(req_ready === 1'b1, "R11 reset ready", {31'd0, req_ready}, 32'd1);
        check(rsp_valid === 1'b0, "R11 reset rsp_valid", {31'd0, rsp_valid}, 32'd0);
        check(mem_req === 1'b0, "R11 reset mem_req", {31'd0, mem_req}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready === 1'b1 && mem_req === 1'b0, "R11 after reset idle", {31'd0, req_ready}, 32'd1);

        // R3 R4 R2: read sweep over every alias word at every size
        for (int w = 0; w < 2; w++) begin
            ab = (w == 0) ? AB0 : AB1;
            for (int s = 0; s < 3; s++) begin
                sz = 1 << s;
                for (int k = 0; k < NWORDS; k++) begin
                    logic [31:0] e;
                    bi = exp_byte(k * 4, sz);
                    e  = {31'd0, mem[w][bi][exp_bit(k * 4, sz)]};
                    do_op(1'b0, ab + 32'(k * 4), 3'(sz), 1'b0, rd, err, xf);
                    check(rd === e && !err && xf == 1, "R3 R4 read bit", rd, e);
                end
            end
        end

        // R5 R2: word writes over every alias word
        for (int w = 0; w < 2; w++) begin
            ab = (w == 0) ? AB0 : AB1;
            for (int k = 0; k < NWORDS; k++) begin
                bit v;
                v  = 1'((k ^ (k >> 3) ^ w) & 1);
                bi = exp_byte(k * 4, 4);
                shadow[w][bi][exp_bit(k * 4, 4)] = v;
                do_op(1'b1, ab + 32'(k * 4), 3'd4, v, rd, err, xf);
                check(!err && xf == 2 && rd == 32'd0, "R5 word write response", {30'd0, err, 1'b0}, 32'd0);
                check(mem_matches(), "R5 word write memory image", 32'(k), 32'(k));
            end
        end

        // R5 R4: byte and halfword writes, one target region each
        for (int s = 0; s < 2; s++) begin
            sz = 1 << s;
            for (int k = 0; k < NWORDS; k++) begin
                bit v;
                v  = 1'(((k >> 1) ^ s) & 1);
                bi = exp_byte(k * 4, sz);
                shadow[s][bi][exp_bit(k * 4, sz)] = v;
                do_op(1'b1, ((s == 0) ? AB0 : AB1) + 32'(k * 4), 3'(sz), v, rd, err, xf);
                check(!err && xf == 2, "R5 sub-word write response", 32'(xf), 32'd2);
                check(mem_matches(), "R5 sub-word write memory image", 32'(k), 32'(k));
            end
        end

        // R1: addresses just outside the windows
        begin
            logic [31:0] outs [4];
            outs[0] = AB0 + 32'(1 << SPAN_LOG2);
            outs[1] = AB0 - 32'd4;
            outs[2] = AB1 + 32'(1 << SPAN_LOG2);
            outs[3] = 32'h3200_0000;
            for (int i = 0; i < 4; i++) begin
                do_op(1'b1, outs[i], 3'd4, 1'b1, rd, err, xf);
                check(err && xf == 0, "R1 outside window rejected", 32'(xf), 32'd0);
            end
            check(mem_matches(), "R1 memory untouched", 32'd0, 32'd0);
        end

        // R9: illegal size codes
        for (int c = 0; c < 8; c++) begin
            if (c == 1 || c == 2 || c == 4) continue;
            do_op(1'b1, AB0 + 32'd8, 3'(c), 1'b1, rd, err, xf);
            check(err && xf == 0, "R9 illegal size rejected", 32'(xf), 32'd0);
        end
        check(mem_matches(), "R9 memory untouched", 32'd0, 32'd0);

        // R7: downstream read error
        inj_rd_err = 1'b1;
        do_op(1'b1, AB0 + 32'd4, 3'd4, ~mem[0][0][1], rd, err, xf);
        check(err && xf == 1, "R7 write stops after read error", 32'(xf), 32'd1);
        check(mem_matches(), "R7 memory untouched", 32'd0, 32'd0);
        do_op(1'b0, AB1, 3'd2, 1'b0, rd, err, xf);
        check(err && xf == 1, "R7 read error reported", {31'd0, err}, 32'd1);
        inj_rd_err = 1'b0;

        // R8: downstream write error
        inj_wr_err = 1'b1;
        do_op(1'b1, AB1 + 32'd12, 3'd1, 1'b1, rd, err, xf);
        check(err && xf == 2, "R8 write error reported", {31'd0, err}, 32'd1);
        inj_wr_err = 1'b0;

        // R6: lock behaviour over the whole run
        check(lock_bad == 0, "R6 lock discipline", 32'(lock_bad), 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule